// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, one destination address at a time, whether a received frame should be kept. The six address bytes arrive on a byte stream. A marker flags the first byte. While the bytes arrive, a bit-serial CRC-32 is folded over them. The six most significant bits of the finished CRC pick one bit out of a 64-entry hash table. That bit decides whether a group (multicast) address passes.

Besides the hash path, the block handles three other cases. Individual addresses are compared with a programmed station address. The all-ones broadcast address is handled separately. A promiscuous mode admits everything. The table, the station address and the mode bits sit in small registers behind a simple write port. The receive path reads only the one-cycle verdict pulse that follows the last address byte, together with the hash index that was used.

Top module: `mcast_hash_filter`

## Requirements
- R1: The CRC starts at 0xFFFFFFFF on the byte marked as first. Each byte is folded in least significant bit first, in arrival order. For each bit, the feedback is the CRC's top bit XOR the data bit. The CRC then shifts left by one, and when the feedback is 1 it is XORed with 0x04C11DB6 and its bit 0 is forced to 1. `dec_index` reports CRC bits 31..26 of the completed address.
- R2: For a group address, the table bit at the hash index decides acceptance. Index 0..31 reads bit `index` of table word 0. Index 32..63 reads bit `index-32` of table word 1. A group address has bit 0 of its first byte set and is not all ones.
- R3: When the all-multicast bit or the promiscuous bit is set, every group address is accepted, whatever the table holds.
- R4: When the promiscuous bit is set, every completed address is accepted.
- R5: Outside promiscuous mode, the address FF:FF:FF:FF:FF:FF is accepted exactly when the broadcast bit is set. The table and the all-multicast bit do not affect it.
- R6: Outside promiscuous mode, an individual address (bit 0 of the first byte clear) is accepted only when the own-address bit is set and all 48 bits equal the station address. Byte k of the address is compared with station bits 8k+7..8k.
- R7: `dec_valid` is high for exactly the one cycle after the clock edge that takes the sixth byte. `dec_accept` is low whenever `dec_valid` is low.
- R8: A byte counts only when `in_valid` is high. A byte with `in_start` high restarts the address, even part way through one. Idle cycles between bytes are allowed. Bytes that arrive after the sixth byte without a new start are ignored and produce no decision.
- R9: After reset, the table, the station address and all mode bits are zero, and `dec_valid` and `dec_accept` are low.
- R10: Write selects: 0 is table word 0, 1 is table word 1, 2 is station bytes 0..3 (byte 0 in bits 7..0), and 3 is station bytes 4..5 in bits 15..0. Select 4 is the mode register: bit 0 promiscuous, bit 1 all-multicast, bit 2 broadcast, bit 3 own-address. A write takes effect at the clock edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| in_valid | input | 1 | Address byte present on `in_byte` |
| in_start | input | 1 | This byte is the first of an address |
| in_byte | input | 8 | Address byte |
| dec_valid | output | 1 | Verdict pulse, one cycle |
| dec_accept | output | 1 | Frame accepted (qualified by `dec_valid`) |
| dec_index | output | 6 | Hash index of the last completed address |

## Verification
The checker watches the pulse shape of the verdict on every cycle. The pulse is never two cycles long. It only follows a cycle that carried a byte. `dec_accept` never stands without `dec_valid`. Whenever promiscuous mode was set at the deciding edge, the verdict is an accept. The bench's scenarios are what show the CRC arithmetic and the table bit selection, including the word boundary between index 31 and 32. They also cover the broadcast and station-address rules, and the restart, gap and excess-byte handling of the stream.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int BYTE_W      = 8;
  localparam int CRC_W       = 32;
  localparam int IDX_W       = 6;
  localparam int WORD_W      = 32;
  localparam int TBL_WORDS   = (1 << IDX_W) / WORD_W;
  localparam int SEL_W       = 3;
  localparam int MODE_W      = 4;

  localparam logic [CRC_W-1:0] CRC_SEED = {CRC_W{1'b1}};
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB6;

  // write select codes; table words occupy 0 .. TBL_WORDS-1
  localparam logic [SEL_W-1:0] SEL_STA_LO = 3'd2;
  localparam logic [SEL_W-1:0] SEL_STA_HI = 3'd3;
  localparam logic [SEL_W-1:0] SEL_MODE   = 3'd4;

  typedef struct packed {
    logic own_en;    // bit 3
    logic bcast_en;  // bit 2
    logic allmc_en;  // bit 1
    logic promisc;   // bit 0
  } mode_t;

  // fold one byte into the CRC, least significant bit first
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] crc_in,
                                                     input logic [BYTE_W-1:0] data);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_in;
    for (int b = 0; b < BYTE_W; b++) begin
      fb = c[CRC_W-1] ^ data[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = (c ^ CRC_POLY) | {{(CRC_W-1){1'b0}}, 1'b1};
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_seq.sv
module mhf_seq
  import mhf_pkg::*;
#(
  parameter int N_BYTES = 6,
  localparam int CNT_W  = $clog2(N_BYTES),
  localparam int ADDR_W = N_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              take,
  output logic              last,
  output logic [ADDR_W-1:0] addr_full
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(N_BYTES - 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  pos;

  always_comb begin
    take   = in_valid && (in_start || busy_q);
    pos    = in_start ? '0 : cnt_q;
    last   = take && (pos == LAST_POS);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    if (take) begin
      if (in_start) addr_d = '0;
      for (int i = 0; i < N_BYTES; i++) begin
        if (pos == CNT_W'(i)) addr_d[i*BYTE_W +: BYTE_W] = in_byte;
      end
      if (last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        busy_d = 1'b1;
        cnt_d  = pos + 1'b1;
      end
    end
    addr_full = addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (take) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit
  import mhf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [CRC_W-1:0]  crc_nxt
);
  logic [CRC_W-1:0] crc_q;

  always_comb begin
    crc_nxt = crc_fold_byte(first ? CRC_SEED : crc_q, in_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= CRC_SEED;
    else if (take) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
#(
  parameter int N_BYTES = 6,
  localparam int ADDR_W = N_BYTES * BYTE_W,
  localparam int STA_HI_W = ADDR_W - WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              last,
  input  logic [ADDR_W-1:0] addr_full,
  input  logic [CRC_W-1:0]  crc_nxt,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [IDX_W-1:0]  dec_index,
  output logic              mode_promisc
);
  localparam int WSEL_W = (TBL_WORDS > 1) ? $clog2(TBL_WORDS) : 1;

  logic [WORD_W-1:0]   tbl_q [TBL_WORDS];
  logic [WORD_W-1:0]   sta_lo_q;
  logic [STA_HI_W-1:0] sta_hi_q;
  mode_t               mode_q;

  // table words, one register per word
  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_tbl
    logic wr_hit;
    assign wr_hit = wr_en && (wr_sel == SEL_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tbl_q[w] <= '0;
      else if (wr_hit) tbl_q[w] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      mode_q   <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_STA_LO) sta_lo_q <= wr_data;
      if (wr_sel == SEL_STA_HI) sta_hi_q <= wr_data[STA_HI_W-1:0];
      if (wr_sel == SEL_MODE)   mode_q   <= mode_t'(wr_data[MODE_W-1:0]);
    end
  end

  // verdict for the address completed by the current byte
  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel;
  logic              tbl_bit, is_bcast, is_group, is_own, acc;

  always_comb begin
    idx      = crc_nxt[CRC_W-1 -: IDX_W];
    wsel     = WSEL_W'(idx >> $clog2(WORD_W));
    tbl_bit  = tbl_q[wsel][idx[$clog2(WORD_W)-1:0]];
    is_bcast = &addr_full;
    is_group = addr_full[0];
    is_own   = (addr_full == {sta_hi_q, sta_lo_q});
    if (mode_q.promisc)  acc = 1'b1;
    else if (is_bcast)   acc = mode_q.bcast_en;
    else if (is_group)   acc = mode_q.allmc_en | tbl_bit;
    else                 acc = mode_q.own_en & is_own;
  end

  logic             vld_d, acc_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    vld_d = last;
    acc_d = last & acc;
    idx_d = last ? idx : dec_index;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_index  <= '0;
    end else begin
      dec_valid  <= vld_d;
      dec_accept <= acc_d;
      dec_index  <= idx_d;
    end
  end

  assign mode_promisc = mode_q.promisc;
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int N_BYTES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [IDX_W-1:0]  dec_index
);
  localparam int ADDR_W = N_BYTES * BYTE_W;

  logic              take, last, mode_promisc;
  logic [ADDR_W-1:0] addr_full;
  logic [CRC_W-1:0]  crc_nxt;

  mhf_seq #(.N_BYTES(N_BYTES)) seq_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
    .in_byte(in_byte), .take(take), .last(last), .addr_full(addr_full)
  );

  mhf_crc_unit crc_i (
    .clk(clk), .rst_n(rst_n), .take(take), .first(in_start),
    .in_byte(in_byte), .crc_nxt(crc_nxt)
  );

  mhf_decide #(.N_BYTES(N_BYTES)) dec_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .last(last), .addr_full(addr_full), .crc_nxt(crc_nxt),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_index(dec_index),
    .mode_promisc(mode_promisc)
  );
endmodule

// File: rtl/mhf_chk.sv
module mhf_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic dec_valid,
  input logic dec_accept,
  input logic promisc
);
  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R7
  after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(in_valid));

  // R7
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept);

  // R4
  promisc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(promisc)) |-> dec_accept);
endmodule

bind mcast_hash_filter mhf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .promisc(mode_promisc)
);

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;
  localparam int CLK_P = 10;

  logic        clk, rst_n, wr_en, in_valid, in_start;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic [7:0]  in_byte;
  logic        dec_valid, dec_accept;
  logic [5:0]  dec_index;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] sh_tbl;
  logic [47:0] sh_sta;
  logic [3:0]  sh_mode; // [0] promisc [1] allmc [2] bcast [3] own

  mcast_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .in_valid(in_valid), .in_start(in_start), .in_byte(in_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_index(dec_index)
  );

  initial begin
    clk = 0;
    forever #(CLK_P/2) clk = ~clk;
  end

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[31] ^ a[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    return c[31:26];
  endfunction

  function automatic logic ref_acc(input logic [47:0] a);
    if (sh_mode[0]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return sh_mode[2];
    if (a[0]) return sh_mode[1] | sh_tbl[ref_idx(a)];
    return sh_mode[3] & (a == sh_sta);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_tbl(input logic [63:0] t);
    sh_tbl = t;
    wr_reg(3'd0, t[31:0]);
    wr_reg(3'd1, t[63:32]);
  endtask

  task automatic set_sta(input logic [47:0] s);
    sh_sta = s;
    wr_reg(3'd2, s[31:0]);
    wr_reg(3'd3, {16'h0, s[47:32]});
  endtask

  task automatic set_mode(input logic [3:0] m);
    sh_mode = m;
    wr_reg(3'd4, {28'h0, m});
  endtask

  // byte i of the address in a[8i+7:8i]; optional idle cycle before byte gap_at
  task automatic send(input logic [47:0] a, input int gap_at);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == gap_at) begin
        in_valid = 0; in_start = 0;
        @(negedge clk);
      end
      in_valid = 1; in_start = (i == 0); in_byte = a[8*i +: 8];
    end
    @(negedge clk);
    in_valid = 0; in_start = 0;
  endtask

  task automatic frame_check(input string tag, input logic [47:0] a, input int gap_at);
    send(a, gap_at);
    chk({tag, " valid"}, {31'b0, dec_valid}, 32'd1);
    chk({tag, " accept"}, {31'b0, dec_accept}, {31'b0, ref_acc(a)});
    chk({tag, " index R1"}, {26'b0, dec_index}, {26'b0, ref_idx(a)});
  endtask

  function automatic logic [47:0] rand_addr(input logic grp);
    logic [47:0] a = {$urandom(), $urandom()};
    a[0] = grp;
    return a;
  endfunction

  function automatic logic [47:0] find_idx(input logic [5:0] want);
    for (int k = 0; k < 5000; k++) begin
      logic [47:0] a = rand_addr(1'b1);
      if (ref_idx(a) == want && a != 48'hFFFF_FFFF_FFFF) return a;
    end
    return 48'h0;
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b;
    void'($urandom(32'd7321));
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    in_valid = 0; in_start = 0; in_byte = 0;
    sh_tbl = '0; sh_sta = '0; sh_mode = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {31'b0, dec_valid}, 32'd0);
    chk("R9 reset accept", {31'b0, dec_accept}, 32'd0);
    rst_n = 1;

    // R9: cleared table rejects a group address
    a = rand_addr(1'b1);
    frame_check("R9 cleared table", a, -1);
    chk("R9 cleared reject", {31'b0, dec_accept}, 32'd0);

    // R7: pulse lasts one cycle
    @(negedge clk);
    chk("R7 pulse end", {31'b0, dec_valid}, 32'd0);

    // R2: word boundary, index 31 vs 32
    a = find_idx(6'd31);
    b = find_idx(6'd32);
    set_tbl(64'h0000_0000_8000_0000);
    frame_check("R2 idx31 low word", a, -1);
    chk("R2 idx31 hit", {31'b0, dec_accept}, 32'd1);
    frame_check("R2 idx32 not low", b, -1);
    chk("R2 idx32 miss", {31'b0, dec_accept}, 32'd0);
    set_tbl(64'h0000_0001_0000_0000);
    frame_check("R2 idx32 high word", b, -1);
    chk("R2 idx32 hit", {31'b0, dec_accept}, 32'd1);
    frame_check("R2 idx31 not high", a, -1);
    chk("R2 idx31 miss", {31'b0, dec_accept}, 32'd0);

    // R3: all-multicast ignores empty table
    set_tbl(64'h0);
    set_mode(4'b0010);
    frame_check("R3 allmc", rand_addr(1'b1), -1);
    chk("R3 allmc accept", {31'b0, dec_accept}, 32'd1);

    // R5: broadcast depends only on its own bit
    set_tbl({64{1'b1}});
    set_mode(4'b1010);
    frame_check("R5 bcast off", 48'hFFFF_FFFF_FFFF, -1);
    chk("R5 bcast rejected", {31'b0, dec_accept}, 32'd0);
    set_mode(4'b0100);
    frame_check("R5 bcast on", 48'hFFFF_FFFF_FFFF, -1);
    chk("R5 bcast accepted", {31'b0, dec_accept}, 32'd1);

    // R6 / R10: station address compare
    a = rand_addr(1'b0);
    set_sta(a);
    set_mode(4'b0000);
    frame_check("R6 own disabled", a, -1);
    chk("R6 own disabled reject", {31'b0, dec_accept}, 32'd0);
    set_mode(4'b1000);
    frame_check("R10 own match", a, -1);
    chk("R6 own match accept", {31'b0, dec_accept}, 32'd1);
    frame_check("R6 own mismatch", a ^ 48'h8000_0000_0000, -1);
    chk("R6 mismatch reject", {31'b0, dec_accept}, 32'd0);

    // R4: promiscuous passes a foreign unicast
    set_mode(4'b0001);
    frame_check("R4 promisc", a ^ 48'h0000_0100_0000, -1);
    chk("R4 promisc accept", {31'b0, dec_accept}, 32'd1);

    // R8: restart mid-address, idle gaps, excess bytes
    set_mode(4'b1000);
    set_tbl(64'h0);
    b = a ^ 48'h0000_0000_0200;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1; in_start = (i == 0); in_byte = b[8*i +: 8];
    end
    frame_check("R8 restart", a, -1);
    chk("R8 restart accept", {31'b0, dec_accept}, 32'd1);
    frame_check("R8 gap", a, 3);
    chk("R8 gap accept", {31'b0, dec_accept}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R8 excess no decision", {31'b0, dec_valid}, 32'd0);
      in_valid = 1; in_start = 0; in_byte = 8'(i);
    end
    @(negedge clk);
    in_valid = 0;
    chk("R8 excess no decision", {31'b0, dec_valid}, 32'd0);

    // random mix against the reference
    for (int n = 0; n < 60; n++) begin
      set_tbl({$urandom(), $urandom()});
      set_mode(4'($urandom()));
      if (n % 4 == 0) a = sh_sta;
      else if (n % 9 == 0) a = 48'hFFFF_FFFF_FFFF;
      else a = rand_addr(1'($urandom()));
      frame_check("R1 R2 R3 R4 R5 R6 random", a, (n % 3 == 0) ? int'($urandom_range(1, 5)) : -1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule